// File: doc/BRIEF.md
# Frame Transmit Controller with Hardware Retry

This block holds one outgoing frame of up to sixteen bytes, written over a simple byte-wide register port, and gets it onto the bus by asking an abstract bit-level transmitter for attempts. For each attempt the transmitter returns one of four outcomes. The controller decides whether to stop or to try again without any help from software. It keeps separate tallies of refused and under-driven attempts. When it finishes it raises exactly one of three sticky completion flags, which software clears by writing ones.

Software loads the frame bytes and the total length, sets a retry ceiling, and enables the flags it wants on the interrupt line. It then sets the start bit. That bit reads back as one for as long as the controller owns the frame, and it drops by itself when the job ends. The transmitter fetches frame bytes through a separate index/data pair and sees the frame length directly.

Top module: `cectx_tx_ctrl`

## Requirements
- R1: After a synchronous active-low reset every register reads 0, `att_req` is low and `irq` is low.
- R2: Frame bytes are written at addresses 0x00 to 0x0F and the length at 0x10. A length write above 16 is stored as 16. Both read back over the register port, and the transmitter sees `frm_len` and `frm_byte` = byte at `frm_idx`.
- R3: Address 0x11 bit 0 is the start bit. Writing 1 while idle with a nonzero length starts a job. It reads 1 while the job runs. Writing 1 with length 0, or writing 0 at any time, changes nothing.
- R4: During an attempt `att_req` stays high until a cycle with `att_done` high. `att_result` codes: 0 success, 1 arbitration lost, 2 refused (NACK), 3 low-drive.
- R5: A success result ends the job and sets the done flag, status bit 5.
- R6: An arbitration-lost result ends the job at once with no further attempt and sets status bit 4.
- R7: A NACK adds one to the count in bits [3:0] of address 0x13, and a low-drive result adds one to bits [7:4]. If the number of retries already made equals the limit in bits [6:4] of address 0x12, the job ends and sets status bit 3. Otherwise `att_req` is low for one cycle and a new attempt begins, so a job makes at most limit+1 attempts.
- R8: Both failure counts are reset to 0 when a job starts.
- R9: When a job ends for any reason the start bit reads 0 again, and exactly one of status bits 5, 4, 3 has been set by that job.
- R10: While a job runs, writes to the frame buffer, the length and the retry register are ignored.
- R11: The status register at 0x14 clears bits [5:3] where a 1 is written. A flag set by a completion in the same cycle as a clearing write stays set. Bits [2:0] and [7:6] read 0.
- R12: The mask at 0x15 holds bits [5:0] and reads back. `irq` is high exactly when a status bit in [5:3] and the mask bit at the same position are both set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| att_req | output | 1 | Attempt request to the bit-level transmitter |
| att_done | input | 1 | Attempt finished, result valid |
| att_result | input | 2 | Attempt outcome code |
| frm_len | output | 5 | Frame length in bytes |
| frm_idx | input | 4 | Frame byte index from the transmitter |
| frm_byte | output | 8 | Frame byte at frm_idx |
| irq | output | 1 | Masked completion interrupt |

## Verification
The two actions that can land in the same cycle are a job completing, which sets a status flag, and a software write-one-to-clear of the status register. The bench provokes this by making its transmitter model drive the clearing write on the bus in the exact cycle in which it returns the final result. It leaves an older flag standing beforehand. The result is judged by reading back that only the newly set flag survives while the older one is gone. Random jobs with mixed result scripts and retry limits are compared against a prediction function for flag, counts and attempt total.

// File: rtl/cectx_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the frame transmit controller.
// Assumes an 8-bit register port with a 5-bit address.
package cectx_pkg;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_LEN   = 5'h10;
    localparam logic [ADDR_W-1:0] A_START = 5'h11;
    localparam logic [ADDR_W-1:0] A_RETRY = 5'h12;
    localparam logic [ADDR_W-1:0] A_FCNT  = 5'h13;
    localparam logic [ADDR_W-1:0] A_IST   = 5'h14;
    localparam logic [ADDR_W-1:0] A_IMASK = 5'h15;

    // Status flag positions; the flag vector index is bit - FLAG_LO
    localparam int FLAG_LO  = 3;
    localparam int NFLAG    = 3;
    localparam int FL_EXH   = 0;   // bit 3
    localparam int FL_ARB   = 1;   // bit 4
    localparam int FL_DONE  = 2;   // bit 5

    localparam int LIM_W = 3;
    localparam int CNT_W = 4;

    typedef enum logic [1:0] {
        RES_OK     = 2'd0,
        RES_ARB    = 2'd1,
        RES_NACK   = 2'd2,
        RES_LOWDRV = 2'd3
    } att_res_e;

    typedef enum logic [1:0] {
        SQ_IDLE    = 2'd0,
        SQ_ATTEMPT = 2'd1,
        SQ_GAP     = 2'd2
    } sq_state_e;
endpackage

// File: rtl/cectx_sat_cnt.sv
`timescale 1ns/1ps
// Saturating up-counter with synchronous clear.
// Assumes clr and inc are never needed in the same cycle; clr wins.
module cectx_sat_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Count up on inc, stop at all-ones, return to zero on clr
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q <= '0;
        end else if (inc && (q != {W{1'b1}})) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/cectx_seq.sv
`timescale 1ns/1ps
// Attempt sequencer: issues attempt requests, interprets results,
// counts retries against the limit and reports the final outcome.
// Assumes att_done is only meaningful while att_req is high.
module cectx_seq
    import cectx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LIM_W-1:0] retry_lim,
    input  logic             att_done,
    input  logic [1:0]       att_result,
    output logic             busy,
    output logic             att_req,
    output logic [NFLAG-1:0] flag_set,
    output logic             inc_nack,
    output logic             inc_low,
    output logic             cnt_clr
);
    sq_state_e        st_q, st_d;
    logic [LIM_W-1:0] rtry_q, rtry_d;
    logic             fin_ok, fin_arb, fin_exh, is_fail, at_limit;

    assign att_req  = (st_q == SQ_ATTEMPT);
    assign busy     = (st_q != SQ_IDLE);
    assign cnt_clr  = start && (st_q == SQ_IDLE);
    assign at_limit = (rtry_q == retry_lim);

    // Classify the result of the attempt that ends this cycle
    always_comb begin
        fin_ok   = 1'b0;
        fin_arb  = 1'b0;
        is_fail  = 1'b0;
        inc_nack = 1'b0;
        inc_low  = 1'b0;
        if (att_req && att_done) begin
            unique case (att_res_e'(att_result))
                RES_OK:     fin_ok   = 1'b1;
                RES_ARB:    fin_arb  = 1'b1;
                RES_NACK:   begin is_fail = 1'b1; inc_nack = 1'b1; end
                RES_LOWDRV: begin is_fail = 1'b1; inc_low  = 1'b1; end
                default:    is_fail = 1'b0;
            endcase
        end
        fin_exh = is_fail && at_limit;
    end

    assign flag_set[FL_DONE] = fin_ok;
    assign flag_set[FL_ARB]  = fin_arb;
    assign flag_set[FL_EXH]  = fin_exh;

    // Next-state and retry-count selection
    always_comb begin
        st_d   = st_q;
        rtry_d = rtry_q;
        unique case (st_q)
            SQ_IDLE: begin
                if (start) begin
                    st_d   = SQ_ATTEMPT;
                    rtry_d = '0;
                end
            end
            SQ_ATTEMPT: begin
                if (fin_ok || fin_arb || fin_exh) begin
                    st_d = SQ_IDLE;
                end else if (is_fail) begin
                    st_d   = SQ_GAP;
                    rtry_d = rtry_q + 1'b1;
                end
            end
            SQ_GAP:  st_d = SQ_ATTEMPT;
            default: st_d = SQ_IDLE;
        endcase
    end

    // State and retry-count registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= SQ_IDLE;
            rtry_q <= '0;
        end else begin
            st_q   <= st_d;
            rtry_q <= rtry_d;
        end
    end
endmodule

// File: rtl/cectx_regs.sv
`timescale 1ns/1ps
// Register file: frame buffer, length, retry limit, status flags with
// write-one-to-clear, interrupt mask and the read multiplexer.
// Assumes MAX_BYTES <= 16 so the buffer fits below the control registers.
module cectx_regs
    import cectx_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic              busy,
    input  logic [NFLAG-1:0]  flag_set,
    input  logic [CNT_W-1:0]  nack_cnt,
    input  logic [CNT_W-1:0]  low_cnt,
    output logic              start,
    output logic [LIM_W-1:0]  retry_lim,
    output logic [LEN_W-1:0]  frm_len,
    input  logic [IDX_W-1:0]  frm_idx,
    output logic [7:0]        frm_byte,
    output logic [NFLAG-1:0]  st_flags,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] BUF_TOP = ADDR_W'(MAX_BYTES);
    localparam logic [7:0]        LEN_MAX = 8'(MAX_BYTES);

    logic [7:0]       buf_q [MAX_BYTES];
    logic [LEN_W-1:0] len_q;
    logic [LIM_W-1:0] lim_q;
    logic [5:0]       mask_q;
    logic             cfg_wr, buf_wr, ist_wr;

    assign cfg_wr = reg_wr && !busy;
    assign buf_wr = cfg_wr && (reg_addr < BUF_TOP);
    assign ist_wr = reg_wr && (reg_addr == A_IST);
    assign start  = cfg_wr && (reg_addr == A_START) && reg_wdata[0] && (len_q != '0);

    assign retry_lim = lim_q;
    assign frm_len   = len_q;
    assign frm_byte  = buf_q[frm_idx];

    // Frame byte storage, frozen while a job runs
    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_BYTES; i++) begin
            if (!rst_n) begin
                buf_q[i] <= '0;
            end else if (buf_wr && (reg_addr[IDX_W-1:0] == IDX_W'(i))) begin
                buf_q[i] <= reg_wdata;
            end
        end
    end

    // Length, retry limit and mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q  <= '0;
            lim_q  <= '0;
            mask_q <= '0;
        end else begin
            if (cfg_wr && reg_addr == A_LEN) begin
                len_q <= (reg_wdata > LEN_MAX) ? LEN_W'(MAX_BYTES) : reg_wdata[LEN_W-1:0];
            end
            if (cfg_wr && reg_addr == A_RETRY) begin
                lim_q <= reg_wdata[4 +: LIM_W];
            end
            if (reg_wr && reg_addr == A_IMASK) begin
                mask_q <= reg_wdata[5:0];
            end
        end
    end

    // Sticky completion flags; a set in the same cycle beats a clear
    for (genvar f = 0; f < NFLAG; f++) begin : g_flag
        logic fl_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                fl_q <= 1'b0;
            end else begin
                fl_q <= flag_set[f] | (fl_q & ~(ist_wr & reg_wdata[FLAG_LO + f]));
            end
        end
        assign st_flags[f] = fl_q;
    end

    assign irq = |(st_flags & mask_q[FLAG_LO +: NFLAG]);

    // Read multiplexer
    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr < BUF_TOP) begin
            reg_rdata = buf_q[reg_addr[IDX_W-1:0]];
        end else begin
            unique case (reg_addr)
                A_LEN:   reg_rdata = 8'(len_q);
                A_START: reg_rdata = {7'd0, busy};
                A_RETRY: reg_rdata = {1'b0, lim_q, 4'd0};
                A_FCNT:  reg_rdata = {low_cnt, nack_cnt};
                A_IST:   reg_rdata = {2'b00, st_flags, 3'b000};
                A_IMASK: reg_rdata = {2'b00, mask_q};
                default: reg_rdata = 8'h00;
            endcase
        end
    end
endmodule

// File: rtl/cectx_tx_ctrl.sv
`timescale 1ns/1ps
// Top of the frame transmit controller. Joins the register file, the
// attempt sequencer and the two failure counters.
// Assumes a single clock domain and a transmitter that answers each request.
module cectx_tx_ctrl
    import cectx_pkg::*;
#(
    parameter int MAX_BYTES = 16,
    localparam int IDX_W    = $clog2(MAX_BYTES),
    localparam int LEN_W    = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              att_req,
    input  logic              att_done,
    input  logic [1:0]        att_result,
    output logic [LEN_W-1:0]  frm_len,
    input  logic [IDX_W-1:0]  frm_idx,
    output logic [7:0]        frm_byte,
    output logic              irq
);
    logic             busy, start, cnt_clr, inc_nack, inc_low;
    logic [LIM_W-1:0] retry_lim;
    logic [NFLAG-1:0] flag_set, st_flags;
    logic [CNT_W-1:0] nack_cnt, low_cnt;
    logic [1:0]       cnt_inc;
    logic [CNT_W-1:0] cnt_val [2];

    cectx_regs #(.MAX_BYTES(MAX_BYTES)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .busy      (busy),
        .flag_set  (flag_set),
        .nack_cnt  (nack_cnt),
        .low_cnt   (low_cnt),
        .start     (start),
        .retry_lim (retry_lim),
        .frm_len   (frm_len),
        .frm_idx   (frm_idx),
        .frm_byte  (frm_byte),
        .st_flags  (st_flags),
        .irq       (irq)
    );

    cectx_seq seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .retry_lim  (retry_lim),
        .att_done   (att_done),
        .att_result (att_result),
        .busy       (busy),
        .att_req    (att_req),
        .flag_set   (flag_set),
        .inc_nack   (inc_nack),
        .inc_low    (inc_low),
        .cnt_clr    (cnt_clr)
    );

    assign cnt_inc = {inc_low, inc_nack};

    // One saturating counter per failure cause: 0 = NACK, 1 = low-drive
    for (genvar c = 0; c < 2; c++) begin : g_fcnt
        cectx_sat_cnt #(.W(CNT_W)) cnt_i (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (cnt_clr),
            .inc   (cnt_inc[c]),
            .q     (cnt_val[c])
        );
    end

    assign nack_cnt = cnt_val[0];
    assign low_cnt  = cnt_val[1];
endmodule

// File: rtl/cectx_tx_ctrl_chk.sv
`timescale 1ns/1ps
// Property checker for the transmit controller, bound into the top.
module cectx_tx_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       att_req,
    input logic       att_done,
    input logic [1:0] att_result,
    input logic [2:0] st_flags,
    input logic [3:0] nack_cnt,
    input logic [3:0] low_cnt
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (att_req && !att_done) |=> att_req); // R4

    AST_OK_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (att_req && att_done && att_result == 2'd0) |=> (st_flags[2] && !busy)); // R5

    AST_ARB_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (att_req && att_done && att_result == 2'd1) |=> (!busy && st_flags[1])); // R6

    AST_FAIL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (att_req && att_done && att_result[1]) |=> !att_req); // R7

    AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (nack_cnt == 4'd0 && low_cnt == 4'd0)); // R8

    AST_IDLE_NOREQ: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !att_req); // R9

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && nack_cnt == 4'hF) |=> (nack_cnt == 4'hF)); // R7
endmodule

bind cectx_tx_ctrl cectx_tx_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .att_req    (att_req),
    .att_done   (att_done),
    .att_result (att_result),
    .st_flags   (st_flags),
    .nack_cnt   (nack_cnt),
    .low_cnt    (low_cnt)
);

// File: tb/cectx_tx_ctrl_tb_top.sv
`timescale 1ns/1ps
// Self-checking bench: random jobs plus directed corner cases.
module cectx_tx_ctrl_tb_top;
    localparam logic [4:0] A_LEN = 5'h10, A_START = 5'h11, A_RETRY = 5'h12,
                           A_FCNT = 5'h13, A_IST = 5'h14, A_IMASK = 5'h15;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0, mdl_wr = 1'b0;
    logic [4:0] host_addr = '0, mdl_addr = '0;
    logic [7:0] host_wdata = '0, mdl_wdata = '0;
    logic       reg_wr;
    logic [4:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       att_req, att_done = 1'b0, irq;
    logic [1:0] att_result = '0;
    logic [4:0] frm_len;
    logic [3:0] frm_idx = '0;
    logic [7:0] frm_byte;

    int n_chk = 0, n_err = 0;
    int att_seen = 0;
    int ptr = 0, last_idx = 0, mdl_dly = 1;
    bit clr_on_last = 1'b0;
    logic [1:0] script [8];
    logic [7:0] exp_buf [16];

    assign reg_wr    = host_wr | mdl_wr;
    assign reg_addr  = mdl_wr ? mdl_addr : host_addr;
    assign reg_wdata = mdl_wr ? mdl_wdata : host_wdata;

    always #10 clk = ~clk;

    cectx_tx_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .att_req(att_req),
        .att_done(att_done), .att_result(att_result), .frm_len(frm_len),
        .frm_idx(frm_idx), .frm_byte(frm_byte), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp_v);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp_v);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        int n = 0;
        do begin
            rd(A_START, v);
            n++;
        end while (v[0] && n < 400);
        chk(n < 400, "R9", n, 0);
        repeat (3) @(negedge clk);
    endtask

    // Predicts flag bit, counts and attempt total for a retry limit
    function automatic void predict(input int lim, output int fbit,
                                    output int nk, output int lw, output int att);
        int rt = 0;
        nk = 0; lw = 0; att = 0; fbit = 0;
        for (int i = 0; i < 8; i++) begin
            att++;
            if (script[i] == 2'd0) begin fbit = 5; return; end
            if (script[i] == 2'd1) begin fbit = 4; return; end
            if (script[i] == 2'd2) nk++; else lw++;
            if (rt == lim) begin fbit = 3; return; end
            rt++;
        end
    endfunction

    // Abstract transmitter model; optionally clears status with the last result
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && att_req) begin
                att_seen++;
                repeat (mdl_dly) @(negedge clk);
                att_done   = 1'b1;
                att_result = script[ptr % 8];
                if (clr_on_last && ptr == last_idx) begin
                    mdl_wr = 1'b1; mdl_addr = A_IST; mdl_wdata = 8'h38;
                end
                ptr++;
                @(negedge clk);
                att_done = 1'b0;
                mdl_wr   = 1'b0;
            end
        end
    end

    task automatic load_frame(input int len);
        for (int i = 0; i < len; i++) begin
            exp_buf[i] = 8'($urandom);
            wr(5'(i), exp_buf[i]);
        end
        wr(A_LEN, 8'(len));
    endtask

    // Runs one job with the current script and checks all results
    task automatic run_job(input int len, input int lim, input logic [5:0] msk,
                           input bit clr_last, input logic [2:0] pre_flags);
        int fb, nk, lw, at, a0;
        logic [7:0] v;
        logic [2:0] expf;
        predict(lim, fb, nk, lw, at);
        load_frame(len);
        wr(A_RETRY, 8'(lim << 4));
        wr(A_IMASK, {2'b00, msk});
        for (int i = 0; i < len; i++) begin
            @(negedge clk); frm_idx = 4'(i);
            #1 chk(frm_byte == exp_buf[i], "R2", frm_byte, exp_buf[i]);
        end
        #1 chk(frm_len == 5'(len), "R2", frm_len, len);
        ptr = 0; last_idx = at - 1; clr_on_last = clr_last;
        a0 = att_seen;
        wr(A_START, 8'h01);
        wait_idle();
        clr_on_last = 1'b0;
        expf = 3'(1 << (fb - 3));
        if (!clr_last) expf = expf | pre_flags;
        rd(A_IST, v);
        chk(v == {2'b00, expf, 3'b000}, (fb == 5) ? "R5" : (fb == 4) ? "R6" : "R7",
            v, {2'b00, expf, 3'b000});
        if (clr_last) chk(v == {2'b00, expf, 3'b000}, "R11", v, {2'b00, expf, 3'b000});
        rd(A_FCNT, v);
        chk(v == {4'(lw), 4'(nk)}, "R7", v, {4'(lw), 4'(nk)});
        chk(att_seen - a0 == at, "R7", att_seen - a0, at);
        rd(A_START, v);
        chk(v == 8'h00, "R9", v, 0);
        #1 chk(irq == |(expf & msk[5:3]), "R12", irq, |(expf & msk[5:3]));
    endtask

    initial begin
        #(20 * 150000);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int a0;
        void'($urandom(32'd2718));
        for (int i = 0; i < 8; i++) script[i] = 2'd2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 22; a++) begin
            rd(5'(a), v);
            chk(v == 8'h00, "R1", v, 0);
        end
        chk(att_req == 1'b0 && irq == 1'b0, "R1", {att_req, irq}, 0);

        // R2: length clamp
        wr(A_LEN, 8'h1F);
        rd(A_LEN, v);
        chk(v == 8'd16, "R2", v, 16);

        // R3: start with zero length is ignored
        wr(A_LEN, 8'h00);
        a0 = att_seen;
        wr(A_START, 8'h01);
        rd(A_START, v);
        chk(v == 8'h00, "R3", v, 0);
        repeat (4) @(negedge clk);
        chk(att_seen == a0 && !att_req, "R3", att_seen - a0, 0);

        // Random jobs
        for (int t = 0; t < 30; t++) begin
            for (int i = 0; i < 8; i++) begin
                int r = $urandom % 10;
                script[i] = (r == 0) ? 2'd0 : (r == 1) ? 2'd1 : (r < 6) ? 2'd2 : 2'd3;
            end
            mdl_dly = $urandom % 4;
            wr(A_IST, 8'h38);
            run_job(1 + $urandom % 16, $urandom % 8, 6'($urandom), 1'b0, 3'b000);
        end

        // R10 and R3: writes during a job are ignored
        for (int i = 0; i < 8; i++) script[i] = 2'd3;
        mdl_dly = 6;
        wr(A_IST, 8'h38);
        load_frame(4);
        wr(A_RETRY, 8'h30);
        ptr = 0; a0 = att_seen;
        wr(A_START, 8'h01);
        wr(5'd0, ~exp_buf[0]);
        wr(A_LEN, 8'd1);
        wr(A_RETRY, 8'h00);
        wr(A_START, 8'h00);
        rd(A_START, v);
        chk(v == 8'h01, "R3", v, 1);
        wait_idle();
        rd(5'd0, v);
        chk(v == exp_buf[0], "R10", v, exp_buf[0]);
        rd(A_LEN, v);
        chk(v == 8'd4, "R10", v, 4);
        rd(A_RETRY, v);
        chk(v == 8'h30, "R10", v, 8'h30);
        chk(att_seen - a0 == 4, "R10", att_seen - a0, 4);
        rd(A_FCNT, v);
        chk(v == 8'h40, "R7", v, 8'h40);

        // R8: counts restart at zero on the next job
        script[0] = 2'd0;
        mdl_dly = 2;
        wr(A_IST, 8'h38);
        run_job(3, 5, 6'h3F, 1'b0, 3'b000);
        rd(A_FCNT, v);
        chk(v == 8'h00, "R8", v, 0);

        // R11: completion and clear in the same cycle; done flag pre-set
        script[0] = 2'd2;
        mdl_dly = 1;
        run_job(2, 0, 6'h08, 1'b1, 3'b100);
        rd(A_IST, v);
        chk(v == 8'h08, "R11", v, 8'h08);
        wr(A_IST, 8'hC7);
        rd(A_IST, v);
        chk(v == 8'h08, "R11", v, 8'h08);
        wr(A_IST, 8'h08);
        rd(A_IST, v);
        chk(v == 8'h00, "R11", v, 0);
        #1 chk(irq == 1'b0, "R12", irq, 0);

        // R12: mask readback
        wr(A_IMASK, 8'hFF);
        rd(A_IMASK, v);
        chk(v == 8'h3F, "R12", v, 8'h3F);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule